// File: doc/BRIEF.md
# Serial Link Phase Controller

This block sits on the transmitting end of a low-power point-to-point serial link. The link has one clock lane and a configurable number of data lanes, two by default. The block decides which bus phase the link is in and tells each lane driver which line state to produce. The states are no current, the low logic level, the high logic level, or a running clock. The analog current-mode drivers, the PLL and the payload framing all live outside this block.

When the active-low power-down input is released, the controller enables the local PLL. It then counts a fixed number of pixel-clock cycles for the PLL to lock. Only after that wait does it start the link-up phase, which the transmitter always initiates and in which the clock lane is held high. Link-up lasts a fixed number of cycles. The link then goes to ACTIVE when payload is pending and to IDLE when it is not. In ACTIVE the clock lane toggles and each data lane carries its payload bit. Pulling power-down low returns the link to OFF on the next edge, from any phase, and clears the lock count.

Top module: `slink_phase_ctrl`

## Requirements
- R1: While the synchronous reset is held, and in the first cycle after it, the phase is OFF, every lane code is 00 and the PLL enable is 0.
- R2: In OFF the clock lane and every data lane carry code 00 (no current).
- R3: The clock lane code is 10 (logic high) in LINK-UP and IDLE and 11 (active clock) in ACTIVE. Code 11 never appears in any other phase.
- R4: In LINK-UP and IDLE every data lane carries 01 (logic low). In ACTIVE data lane i carries 10 when its payload bit is 1 and 01 when it is 0.
- R5: The PLL enable output equals the power-down input as sampled at the previous clock edge, and it is 0 after a reset edge.
- R6: From OFF, the phase becomes LINK-UP exactly at the LOCK_CYCLES-th consecutive clock edge (default 4096) at which the power-down input is high and reset is low.
- R7: LINK-UP lasts LINKUP_CYCLES cycles (default 16). At its last edge the phase goes to ACTIVE if data-valid is high and to IDLE otherwise.
- R8: From ACTIVE or IDLE, with power-down high, the next phase is ACTIVE when data-valid is high and IDLE when it is low. Neither phase ever returns to LINK-UP.
- R9: A low power-down input forces OFF at the next edge from any phase and clears the lock count, so an interrupted wait restarts from zero.
- R10: The phase output is encoded OFF=00, LINK-UP=01, ACTIVE=10, IDLE=11, and LINK-UP is entered only from OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pwr_dn_n_i | input | 1 | Power-down, active low |
| data_valid_i | input | 1 | Payload pending |
| lane_bit_i | input | N_DATA_LANES | Payload bit per data lane |
| pll_en_o | output | 1 | PLL enable |
| phase_o | output | 2 | Current bus phase |
| clk_lane_code_o | output | 2 | Line-state code for the clock lane |
| data_lane_code_o | output | 2*N_DATA_LANES | Line-state codes, lane i in bits 2i+1:2i |

## Verification
On every cycle the assertions check several per-cycle properties. They cover the zero-current lanes in OFF, the rule that the active clock code appears only in ACTIVE, the forced OFF after power-down, and the one-edge delay of the PLL enable. They also check that LINK-UP is entered only from OFF and that the ACTIVE/IDLE choice follows data-valid. A counter in the checker ensures that LINK-UP is never reached before the full lock window. Only the bench scenarios can show the exact edge at which the lock wait ends, the length of LINK-UP and the branch taken at its end, and that an interrupted power-up restarts the full 4096-cycle count. The same applies to the payload-bit encoding on each lane in ACTIVE.

// File: rtl/slink_pkg.sv
package slink_pkg;

    typedef enum logic [1:0] {
        PH_OFF    = 2'b00,
        PH_LINKUP = 2'b01,
        PH_ACTIVE = 2'b10,
        PH_IDLE   = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        LN_NONE = 2'b00,
        LN_LOW  = 2'b01,
        LN_HIGH = 2'b10,
        LN_CLK  = 2'b11
    } line_e;

endpackage

// File: rtl/slink_phase_fsm.sv
module slink_phase_fsm
    import slink_pkg::*;
#(
    parameter int LOCK_CYCLES   = 4096,
    parameter int LINKUP_CYCLES = 16
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   pwr_dn_n_i,
    input  logic   data_valid_i,
    output phase_e phase_o,
    output logic   pll_en_o
);

    localparam int MAX_WAIT = (LOCK_CYCLES > LINKUP_CYCLES) ? LOCK_CYCLES : LINKUP_CYCLES;
    localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;
    localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_CYCLES - 1);
    localparam logic [CNT_W-1:0] LINKUP_LAST = CNT_W'(LINKUP_CYCLES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             pll_en;
    } fsm_state_t;

    localparam fsm_state_t RESET_ST = '{phase: PH_OFF, cnt: '0, pll_en: 1'b0};

    fsm_state_t st_d, st_q;

    // next-state computation; power-down overrides every phase
    always_comb begin
        st_d        = st_q;
        st_d.pll_en = pwr_dn_n_i;
        if (!pwr_dn_n_i) begin
            st_d.phase = PH_OFF;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.phase)
                PH_OFF: begin
                    if (st_q.cnt == LOCK_LAST) begin
                        st_d.phase = PH_LINKUP;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_LINKUP: begin
                    if (st_q.cnt == LINKUP_LAST) begin
                        st_d.phase = data_valid_i ? PH_ACTIVE : PH_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_ACTIVE, PH_IDLE: begin
                    st_d.phase = data_valid_i ? PH_ACTIVE : PH_IDLE;
                    st_d.cnt   = '0;
                end
                default: begin
                    st_d.phase = PH_OFF;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign pll_en_o = st_q.pll_en;

endmodule

// File: rtl/slink_lane_enc.sv
module slink_lane_enc
    import slink_pkg::*;
#(
    parameter int N_DATA_LANES = 2
) (
    input  phase_e                     phase_i,
    input  logic [N_DATA_LANES-1:0]    lane_bit_i,
    output logic [1:0]                 clk_code_o,
    output logic [2*N_DATA_LANES-1:0]  data_code_o
);

    line_e clk_d;

    always_comb begin
        unique case (phase_i)
            PH_OFF:    clk_d = LN_NONE;
            PH_ACTIVE: clk_d = LN_CLK;
            default:   clk_d = LN_HIGH;
        endcase
    end

    assign clk_code_o = clk_d;

    for (genvar g = 0; g < N_DATA_LANES; g++) begin : g_lane
        line_e lane_d;
        always_comb begin
            unique case (phase_i)
                PH_OFF:    lane_d = LN_NONE;
                PH_ACTIVE: lane_d = lane_bit_i[g] ? LN_HIGH : LN_LOW;
                default:   lane_d = LN_LOW;
            endcase
        end
        assign data_code_o[2*g +: 2] = lane_d;
    end

endmodule

// File: rtl/slink_phase_ctrl.sv
module slink_phase_ctrl
    import slink_pkg::*;
#(
    parameter int LOCK_CYCLES   = 4096,
    parameter int LINKUP_CYCLES = 16,
    parameter int N_DATA_LANES  = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      pwr_dn_n_i,
    input  logic                      data_valid_i,
    input  logic [N_DATA_LANES-1:0]   lane_bit_i,
    output logic                      pll_en_o,
    output logic [1:0]                phase_o,
    output logic [1:0]                clk_lane_code_o,
    output logic [2*N_DATA_LANES-1:0] data_lane_code_o
);

    phase_e phase_q;

    slink_phase_fsm #(
        .LOCK_CYCLES  (LOCK_CYCLES),
        .LINKUP_CYCLES(LINKUP_CYCLES)
    ) fsm_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .pwr_dn_n_i  (pwr_dn_n_i),
        .data_valid_i(data_valid_i),
        .phase_o     (phase_q),
        .pll_en_o    (pll_en_o)
    );

    slink_lane_enc #(
        .N_DATA_LANES(N_DATA_LANES)
    ) enc_i (
        .phase_i    (phase_q),
        .lane_bit_i (lane_bit_i),
        .clk_code_o (clk_lane_code_o),
        .data_code_o(data_lane_code_o)
    );

    assign phase_o = phase_q;

endmodule

// File: rtl/slink_phase_ctrl_chk.sv
module slink_phase_ctrl_chk #(
    parameter int LOCK_CYCLES  = 4096,
    parameter int N_DATA_LANES = 2
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic                      pwr_dn_n_i,
    input logic                      data_valid_i,
    input logic                      pll_en_o,
    input logic [1:0]                phase_o,
    input logic [1:0]                clk_lane_code_o,
    input logic [2*N_DATA_LANES-1:0] data_lane_code_o
);

    localparam logic [1:0] P_OFF = 2'b00;
    localparam logic [1:0] P_LU  = 2'b01;
    localparam logic [1:0] P_ACT = 2'b10;
    localparam logic [1:0] P_IDL = 2'b11;

    // consecutive edges spent in OFF with power-down released
    logic [31:0] lock_seen;
    always_ff @(posedge clk_i) begin
        if (rst_i || !(phase_o == P_OFF && pwr_dn_n_i)) begin
            lock_seen <= '0;
        end else begin
            lock_seen <= lock_seen + 1;
        end
    end

    assert_off_silent_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_o == P_OFF |-> (clk_lane_code_o == 2'b00 && data_lane_code_o == '0));

    assert_clk_only_active_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        clk_lane_code_o == 2'b11 |-> phase_o == P_ACT);

    assert_pll_follows_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        pwr_dn_n_i |=> pll_en_o);

    assert_pll_drops_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !pwr_dn_n_i |=> !pll_en_o);

    assert_no_early_linkup_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == P_OFF && pwr_dn_n_i && lock_seen != 32'(LOCK_CYCLES - 1)) |=> phase_o == P_OFF);

    assert_steady_active_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        ((phase_o == P_ACT || phase_o == P_IDL) && pwr_dn_n_i && data_valid_i) |=> phase_o == P_ACT);

    assert_steady_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        ((phase_o == P_ACT || phase_o == P_IDL) && pwr_dn_n_i && !data_valid_i) |=> phase_o == P_IDL);

    assert_forced_off_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !pwr_dn_n_i |=> phase_o == P_OFF);

    assert_linkup_from_off_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == P_LU && $past(phase_o) != P_LU) |-> $past(phase_o) == P_OFF);

endmodule

bind slink_phase_ctrl slink_phase_ctrl_chk #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .N_DATA_LANES(N_DATA_LANES)
) chk_i (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .pwr_dn_n_i      (pwr_dn_n_i),
    .data_valid_i    (data_valid_i),
    .pll_en_o        (pll_en_o),
    .phase_o         (phase_o),
    .clk_lane_code_o (clk_lane_code_o),
    .data_lane_code_o(data_lane_code_o)
);

// File: tb/slink_phase_ctrl_tb_top.sv
`timescale 1ns/100ps
module slink_phase_ctrl_tb_top;

    localparam int LOCK = 4096;
    localparam int LU   = 16;
    localparam int NL   = 2;
    localparam int S_OFF = 0, S_LU = 1, S_ACT = 2, S_IDL = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pdn = 1'b0;
    logic          dv  = 1'b0;
    logic [NL-1:0] bits = '0;
    logic          pll_en;
    logic [1:0]    phase;
    logic [1:0]    clk_code;
    logic [2*NL-1:0] dat_code;

    int n_cmp = 0;
    int n_bad = 0;
    int m_phase = S_OFF;
    int m_cnt = 0;
    int m_pll = 0;

    always #2.5 clk = ~clk;

    slink_phase_ctrl #(
        .LOCK_CYCLES(LOCK), .LINKUP_CYCLES(LU), .N_DATA_LANES(NL)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .pwr_dn_n_i(pdn), .data_valid_i(dv),
        .lane_bit_i(bits), .pll_en_o(pll_en), .phase_o(phase),
        .clk_lane_code_o(clk_code), .data_lane_code_o(dat_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_clk(input int ph);
        if (ph == S_OFF) return 0;
        if (ph == S_ACT) return 3;
        return 2;
    endfunction

    function automatic int exp_lane(input int ph, input logic b);
        if (ph == S_OFF) return 0;
        if (ph == S_ACT) return b ? 2 : 1;
        return 1;
    endfunction

    // behavioural reference, one step per clock edge
    task automatic model_step();
        if (rst) begin
            m_phase = S_OFF; m_cnt = 0; m_pll = 0;
        end else begin
            m_pll = pdn;
            if (!pdn) begin
                m_phase = S_OFF; m_cnt = 0;
            end else if (m_phase == S_OFF) begin
                m_cnt++;
                if (m_cnt == LOCK) begin m_phase = S_LU; m_cnt = 0; end
            end else if (m_phase == S_LU) begin
                m_cnt++;
                if (m_cnt == LU) begin m_phase = dv ? S_ACT : S_IDL; m_cnt = 0; end
            end else begin
                m_phase = dv ? S_ACT : S_IDL;
            end
        end
    endtask

    task automatic cycle(input logic r, input logic p, input logic v, input logic [NL-1:0] b);
        rst = r; pdn = p; dv = v; bits = b;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R10 phase", int'(phase), m_phase);
        check("R5 pll_en", int'(pll_en), m_pll);
        check(m_phase == S_OFF ? "R2 clk lane" : "R3 clk lane", int'(clk_code), exp_clk(m_phase));
        for (int i = 0; i < NL; i++)
            check(m_phase == S_OFF ? "R2 data lane" : "R4 data lane",
                  int'(dat_code[2*i +: 2]), exp_lane(m_phase, b[i]));
    endtask

    task automatic run(input int n, input logic p, input logic v);
        for (int i = 0; i < n; i++) cycle(1'b0, p, v, NL'(i * 3 + (i >> 2)));
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b1, '1);
        check("R1 phase", int'(phase), 0);
        check("R1 pll_en", int'(pll_en), 0);
        check("R1 lanes", int'(clk_code) + int'(dat_code), 0);

        // R6: lock wait ends on the LOCK-th edge
        run(LOCK - 1, 1'b1, 1'b0);
        check("R6 still off", int'(phase), S_OFF);
        run(1, 1'b1, 1'b0);
        check("R6 link-up", int'(phase), S_LU);
        check("R3 link-up clk high", int'(clk_code), 2);

        // R7: link-up length, then IDLE
        run(LU - 1, 1'b1, 1'b0);
        check("R7 link-up held", int'(phase), S_LU);
        run(1, 1'b1, 1'b0);
        check("R7 to idle", int'(phase), S_IDL);

        // R8: follow data-valid
        for (int i = 0; i < 40; i++) run(1, 1'b1, ((i % 5) < 3));
        run(1, 1'b1, 1'b1);
        check("R8 active", int'(phase), S_ACT);
        check("R3 active clk", int'(clk_code), 3);
        cycle(1'b0, 1'b1, 1'b1, 2'b10);
        check("R4 lane1 high", int'(dat_code[3:2]), 2);
        check("R4 lane0 low", int'(dat_code[1:0]), 1);

        // R9: forced off and interrupted wait restarts
        run(1, 1'b0, 1'b1);
        check("R9 forced off", int'(phase), S_OFF);
        run(2000, 1'b1, 1'b1);
        run(3, 1'b0, 1'b1);
        run(LOCK - 1, 1'b1, 1'b1);
        check("R9 full wait again", int'(phase), S_OFF);
        run(1, 1'b1, 1'b1);
        check("R9 link-up after restart", int'(phase), S_LU);

        // R7: data-valid at end of link-up goes to ACTIVE
        run(LU, 1'b1, 1'b1);
        check("R7 to active", int'(phase), S_ACT);
        run(10, 1'b1, 1'b1);

        // R1: reset in ACTIVE
        cycle(1'b1, 1'b1, 1'b1, '1);
        check("R1 reset from active", int'(phase), S_OFF);
        check("R1 pll after reset", int'(pll_en), 0);
        run(20, 1'b1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule